// File: doc/BRIEF.md
# Two-Bank Interrupt Event Controller

This block gathers 64 interrupt lines into two 32-bit banks and drives one CPU interrupt request. Bank A covers lines 31..0 and bank B covers lines 63..32. Every clock the block samples each line. It keeps a level image of each line, and a sticky event bit per line that a change of the line sets or clears. Each bank has an enable register, and an event bit can only hold a 1 where its enable bit is 1.

A single mode bit selects how changes are captured. In native mode only a rising change records an event, and a falling change removes it. In legacy mode any change of a line records an event. In legacy mode software can also wipe both event banks with a single write.

Software reaches the block through a 32-bit register port with a 3-bit word address. The read data is combinational. Writes take effect on the clock edge. The CPU request is latched: it rises when an event is pending, and it only falls on an acknowledge write that leaves no event pending.

Top module: `intc_dual_bank`

## Requirements
- R1: Synchronous reset clears every event, enable and level bit and deasserts `cpu_irq`.
- R2: One clock after a line is sampled, the level register bit for that line (address 3 for bank A, address 7 for bank B; bank A holds lines 31..0 and bank B holds lines 63..32) equals the sampled value.
- R3: In native mode (mode bit 0), a sampled 0-to-1 change of a line sets its event bit. A 1-to-0 change clears it. A line that does not change leaves its event bit as it was. Event registers are at address 0 (bank A) and address 4 (bank B).
- R4: In legacy mode (enable-A bit 31 = 1), a change of a line in either direction sets its event bit.
- R5: An event bit is never 1 while its enable bit is 0. The new enable value is applied in the same cycle as the capture.
- R6: A write to enable-A (address 1) replaces that register, and copies bit 31 of the written value into enable-B bit 31.
- R7: A write to enable-B (address 5) ORs the written bits 30..0 into the register. It never clears a bit and never changes bit 31.
- R8: A write to an acknowledge register (address 2 for bank A, address 6 for bank B) clears the event bits of that bank that are 1 in bits 30..0 of the written value. Written bit 31 never clears event bit 31.
- R9: In legacy mode, an acknowledge-A write with bit 31 set zeroes both event registers. In native mode the same write leaves all event bits as they are.
- R10: The acknowledge registers read as zero. Writes to the event registers and level registers are ignored.
- R11: `cpu_irq` is 1 whenever an event register is nonzero. Once set, it stays 1 until an acknowledge write leaves both event registers zero.
- R12: Port data is little-endian. The block byte-swaps the write data, and it byte-swaps the read data, so internal bit 31 travels on port bit 7.
- R13: If a capture and an acknowledge write hit the same event bit in the same cycle, the acknowledge wins and the bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: bit 2 selects the bank, bits 1..0 select the register |
| reg_wdata | input | 32 | Write data, little-endian |
| reg_rdata | output | 32 | Read data for `reg_addr`, little-endian, combinational |
| irq_in | input | 64 | Interrupt lines, sampled every clock |
| cpu_irq | output | 1 | Latched CPU interrupt request |

## Verification
The assertions assume that `irq_in` and the register strobes are synchronous to `clk` and hold steady around the rising edge. They also assume that a single write strobe carries one address. For that reason the properties on the request latch and the wipe only look at one access per cycle. The bench drives every input just after the falling edge. It changes lines one at a time in the directed part, and several at once in the random part. In every cycle it compares the output and the read data of whatever address it is presenting against a behavioural model.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int LINES_W   = WORD_W * NUM_BANKS;
    localparam int ADDR_W    = 3;
    localparam int MODE_BIT  = WORD_W - 1;
    localparam int BYTES     = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t LOW_BITS = ~(word_t'(1) << MODE_BIT);

    typedef enum logic [1:0] {
        SLOT_EVENTS = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_ACK    = 2'd2,
        SLOT_LINES  = 2'd3
    } slot_e;

    typedef struct packed {
        logic  bank;
        slot_e slot;
    } reg_sel_t;

    typedef struct packed {
        logic  en;
        logic  wipe;
        word_t bits;
    } ack_req_t;

    function automatic word_t swap_bytes(word_t w);
        word_t r;
        for (int i = 0; i < BYTES; i++)
            r[8*i +: 8] = w[8*(BYTES-1-i) +: 8];
        return r;
    endfunction
endpackage

// File: rtl/intc_enable_regs.sv
`timescale 1ns/1ps
module intc_enable_regs
    import intc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_BANKS-1:0]           wr,
    input  word_t                          wdata,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] en_q,
    output logic [NUM_BANKS-1:0][WORD_W-1:0] en_d
);
    always_comb begin
        en_d = en_q;
        if (wr[0]) begin
            en_d[0]           = wdata;
            en_d[1][MODE_BIT] = wdata[MODE_BIT];
        end else if (wr[1]) begin
            en_d[1] = en_q[1] | (wdata & LOW_BITS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    p_mode_copy_r6: assert property (@(posedge clk) disable iff (rst)
        en_q[1][MODE_BIT] == en_q[0][MODE_BIT]);

    p_enb_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(en_q[1]) & ~en_q[1] & LOW_BITS) == '0));
endmodule

// File: rtl/intc_event_bank.sv
`timescale 1ns/1ps
module intc_event_bank
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  word_t    lines,
    input  logic     mode,
    input  word_t    en_next,
    input  word_t    en_cur,
    input  ack_req_t ack,
    output word_t    events_q,
    output word_t    events_d,
    output word_t    levels_q
);
    word_t changed, setters, captured, kept;

    always_comb begin
        changed  = lines ^ levels_q;
        setters  = mode ? changed : (changed & lines);
        captured = (events_q & ~changed) | setters;
        kept     = captured & en_next;
        if (ack.wipe)     events_d = '0;
        else if (ack.en)  events_d = kept & ~ack.bits;
        else              events_d = kept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            events_q <= '0;
            levels_q <= '0;
        end else begin
            events_q <= events_d;
            levels_q <= lines;
        end
    end

    p_evt_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (events_q & ~en_cur) == '0);

    p_lvl_track_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> levels_q == $past(lines));
endmodule

// File: rtl/intc_dual_bank.sv
`timescale 1ns/1ps
module intc_dual_bank
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [LINES_W-1:0]   irq_in,
    output logic                 cpu_irq
);
    reg_sel_t sel;
    word_t    wdata;
    logic     mode, ack_hit, wipe, irq_q;
    logic [NUM_BANKS-1:0]             en_wr;
    logic [NUM_BANKS-1:0][WORD_W-1:0] en_q, en_d, ev_q, ev_d, lv_q;
    ack_req_t [NUM_BANKS-1:0]         ack;
    word_t    rd_word;

    assign sel     = reg_sel_t'(reg_addr);
    assign wdata   = swap_bytes(reg_wdata);
    assign mode    = en_q[0][MODE_BIT];
    assign ack_hit = reg_we && (sel.slot == SLOT_ACK);
    assign wipe    = ack_hit && (sel.bank == 1'b0) && mode && wdata[MODE_BIT];

    intc_enable_regs u_enable (
        .clk   (clk),
        .rst   (rst),
        .wr    (en_wr),
        .wdata (wdata),
        .en_q  (en_q),
        .en_d  (en_d)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign en_wr[b]     = reg_we && (sel.slot == SLOT_ENABLE) && (sel.bank == 1'(b));
        assign ack[b].en    = ack_hit && (sel.bank == 1'(b));
        assign ack[b].wipe  = wipe;
        assign ack[b].bits  = wdata & LOW_BITS;

        intc_event_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .lines    (irq_in[b*WORD_W +: WORD_W]),
            .mode     (mode),
            .en_next  (en_d[b]),
            .en_cur   (en_q[b]),
            .ack      (ack[b]),
            .events_q (ev_q[b]),
            .events_d (ev_d[b]),
            .levels_q (lv_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                        irq_q <= 1'b0;
        else if (ack_hit && ev_d == '0) irq_q <= 1'b0;
        else if (ev_d != '0)            irq_q <= 1'b1;
    end
    assign cpu_irq = irq_q;

    always_comb begin
        case (sel.slot)
            SLOT_EVENTS: rd_word = ev_q[sel.bank];
            SLOT_ENABLE: rd_word = en_q[sel.bank];
            SLOT_LINES:  rd_word = lv_q[sel.bank];
            default:     rd_word = '0;
        endcase
        reg_rdata = swap_bytes(rd_word);
    end

    p_irq_cover_r11: assert property (@(posedge clk) disable iff (rst)
        (ev_q != '0) |-> irq_q);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ack_hit) |=> irq_q);

    p_wipe_both_r9: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (ev_q == '0) && !irq_q);
endmodule

// File: tb/sim_intc_dual_bank.sv
`timescale 1ns/1ps
module sim_intc_dual_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [63:0] irq_in;
    logic        cpu_irq;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] m_ev  [2];
    logic [31:0] m_en  [2];
    logic [31:0] m_lv  [2];
    logic        m_irq;

    always #2.5 clk = ~clk;

    intc_dual_bank u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] bsw(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        logic [31:0] wv;
        logic        md;
        int          slot;
        int          bk;
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                m_ev[b] = 0; m_en[b] = 0; m_lv[b] = 0;
            end
            m_irq = 0;
        end else begin
            wv   = bsw(reg_wdata);
            md   = m_en[0][31];
            slot = int'(reg_addr[1:0]);
            bk   = int'(reg_addr[2]);
            for (int b = 0; b < 2; b++)
                for (int i = 0; i < 32; i++)
                    if (irq_in[b*32+i] != m_lv[b][i]) begin
                        m_ev[b][i] = md | irq_in[b*32+i];
                        m_lv[b][i] = irq_in[b*32+i];
                    end
            if (reg_we && slot == 1) begin
                if (bk == 0) begin
                    m_en[0] = wv;
                    m_en[1][31] = wv[31];
                end else begin
                    for (int i = 0; i < 31; i++) if (wv[i]) m_en[1][i] = 1'b1;
                end
            end
            for (int b = 0; b < 2; b++) m_ev[b] = m_ev[b] & m_en[b];
            if (reg_we && slot == 2) begin
                if (bk == 0 && md && wv[31]) begin
                    m_ev[0] = 0; m_ev[1] = 0;
                end else begin
                    for (int i = 0; i < 31; i++) if (wv[i]) m_ev[bk][i] = 1'b0;
                end
            end
            if (reg_we && slot == 2 && m_ev[0] == 0 && m_ev[1] == 0) m_irq = 0;
            else if (m_ev[0] != 0 || m_ev[1] != 0) m_irq = 1;
        end
    end

    function automatic logic [31:0] model_read(logic [2:0] a);
        logic [31:0] v;
        case (a[1:0])
            2'd0: v = m_ev[a[2]];
            2'd1: v = m_en[a[2]];
            2'd3: v = m_lv[a[2]];
            default: v = 0;
        endcase
        return bsw(v);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock; compare against the model at the falling edge
    task automatic tick();
        string tag;
        @(negedge clk);
        case (reg_addr[1:0])
            2'd0: tag = "R3 events";
            2'd1: tag = "R6 enable";
            2'd2: tag = "R10 ack-read";
            default: tag = "R2 levels";
        endcase
        chk("R11 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
        chk(tag, reg_rdata, model_read(reg_addr));
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = bsw(reg_rdata);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = bsw(v);
        tick();
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_we = 1'b0; reg_addr = 0; reg_wdata = 0; irq_in = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        peek(3'd0, v); chk("R1 events A", v, 32'h0);
        peek(3'd1, v); chk("R1 enable A", v, 32'h0);
        peek(3'd7, v); chk("R1 levels B", v, 32'h0);
        chk("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);

        wr(3'd1, 32'h0000_00F0);
        peek(3'd1, v); chk("R6 enable A", v, 32'h0000_00F0);
        chk("R12 raw byte order", reg_rdata, 32'hF000_0000);
        peek(3'd5, v); chk("R6 mode copy 0", v, 32'h0);

        irq_in[4] = 1'b1; tick();
        peek(3'd0, v); chk("R3 rise sets", v, 32'h10);
        chk("R11 set", {31'b0, cpu_irq}, 32'h1);
        peek(3'd3, v); chk("R2 level", v, 32'h10);
        tick();
        peek(3'd0, v); chk("R3 steady holds", v, 32'h10);
        irq_in[4] = 1'b0; tick();
        peek(3'd0, v); chk("R3 fall clears", v, 32'h0);
        chk("R11 latched", {31'b0, cpu_irq}, 32'h1);
        wr(3'd2, 32'h10);
        chk("R11 released", {31'b0, cpu_irq}, 32'h0);

        irq_in[8] = 1'b1; tick();
        peek(3'd0, v); chk("R5 disabled bit", v, 32'h0);
        peek(3'd3, v); chk("R2 level bit8", v, 32'h100);

        wr(3'd5, 32'h8000_0003);
        wr(3'd5, 32'h0000_0004);
        peek(3'd5, v); chk("R7 OR only", v, 32'h0000_0007);

        irq_in[33] = 1'b1; tick();
        peek(3'd4, v); chk("R3 bank B rise", v, 32'h2);
        wr(3'd6, 32'h8000_0000);
        peek(3'd4, v); chk("R8 bit31 ignored", v, 32'h2);
        wr(3'd6, 32'h0000_0002);
        peek(3'd4, v); chk("R8 ack clears", v, 32'h0);
        chk("R11 released B", {31'b0, cpu_irq}, 32'h0);

        wr(3'd1, 32'h8000_00F0);
        peek(3'd5, v); chk("R6 mode copy 1", v, 32'h8000_0007);
        irq_in[5] = 1'b1; tick();
        peek(3'd0, v); chk("R4 rise sets", v, 32'h20);
        wr(3'd2, 32'h20);
        irq_in[5] = 1'b0; tick();
        peek(3'd0, v); chk("R4 fall sets", v, 32'h20);
        irq_in[32] = 1'b1; tick();
        peek(3'd4, v); chk("R4 bank B", v, 32'h1);
        wr(3'd2, 32'h8000_0000);
        peek(3'd0, v); chk("R9 wipe A", v, 32'h0);
        peek(3'd4, v); chk("R9 wipe B", v, 32'h0);
        chk("R9 irq off", {31'b0, cpu_irq}, 32'h0);

        wr(3'd1, 32'h0000_00F0);
        peek(3'd5, v); chk("R6 mode copy back", v, 32'h0000_0007);
        irq_in[6] = 1'b1; tick();
        wr(3'd2, 32'h8000_0000);
        peek(3'd0, v); chk("R9 native no wipe", v, 32'h40);
        wr(3'd1, 32'h0);
        peek(3'd0, v); chk("R5 enable drop", v, 32'h0);
        chk("R11 still latched", {31'b0, cpu_irq}, 32'h1);
        wr(3'd2, 32'h0);
        chk("R11 empty ack", {31'b0, cpu_irq}, 32'h0);
        wr(3'd1, 32'h0000_00F0);

        irq_in[7] = 1'b1;
        wr(3'd2, 32'h80);
        peek(3'd0, v); chk("R13 ack wins", v, 32'h0);

        peek(3'd2, v); chk("R10 ack A reads 0", v, 32'h0);
        peek(3'd6, v); chk("R10 ack B reads 0", v, 32'h0);
        irq_in[4] = 1'b1; tick();
        wr(3'd0, 32'h0);
        peek(3'd0, v); chk("R10 event write ignored", v, 32'h10);
        wr(3'd3, 32'h0);
        peek(3'd3, v); chk("R10 level write ignored", v, irq_in[31:0]);
        wr(3'd2, 32'h10);

        for (int n = 0; n < 3000; n++) begin
            irq_in    = irq_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            reg_addr  = 3'($urandom);
            reg_we    = ($urandom % 4) == 0;
            reg_wdata = $urandom;
            tick();
        end
        reg_we = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule